// File: doc/BRIEF.md
# Serial port register bank

This block is the software-visible register bank of a simple serial port with a receive FIFO. A host issues single-cycle reads and writes on a byte-offset address bus covering a 40-byte window of ten word-aligned registers. The bank holds the mode, baud divisor, control, FIFO control and pin registers. It keeps five status flags, drives the transmit and receive interrupt lines, and turns writes to the transmit data offset into a one-cycle transmit strobe. Transmission is treated as finishing at once.

A separate receive FIFO sits beside the bank. The bank asks it for pops and clears and tells it the fill trigger level. The FIFO reports its fill count and head byte, plus event pulses that set or clear the receive-full flag and set the data-ready flag. The serial shifters and baud generator are outside this block.

Transmit stream rules: `tx_valid` is high for exactly the access cycle of a transmit-data write, with `tx_data` valid in that same cycle. There is no ready input, so the consumer must take every strobe. On the receive side, `rx_ready` is the receive-enable control bit. An upstream receiver must hold bytes back while it is low.

Top module: `sport_csr_bank`

## Requirements
- R1: After reset the status register reads 0x60, the baud register reads 0xFF, the control register reads 0x20, and the mode, FIFO control and pin registers read 0x00. Both interrupts are low and the trigger level is 1.
- R2: Register offsets are: mode 0x00, baud 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, receive count 0x1C, pin 0x20 and line status 0x24. Writes are masked before storage: mode with 0x7B, control with 0xFA, pin with 0xF3. Baud and FIFO control store all eight bits, and every stored register reads back.
- R3: A write to 0x0C raises `tx_valid` in that cycle with `tx_data` equal to the written byte. From the next cycle the transmit-empty flag is clear.
- R4: A control write with bit 5 clear sets the transmit-end flag.
- R5: `tx_irq` equals control bit 7 from the cycle after each control write.
- R6: Status bits are: transmit-end bit 6, transmit-empty bit 5, break bit 4, receive-full bit 1, data-ready bit 0, with all other bits 0. Writing 0 to one of these bits clears that flag, and writing 1 leaves it unchanged.
- R7: A status read returns the current flags. If control bit 5 is set, transmit-empty and transmit-end are then both set. If it is clear, they are left alone.
- R8: `rx_irq` rises after a `fifo_full_set` pulse while control bit 6 is set. It falls after a control write with bit 6 clear, or after a status write with bit 1 or bit 0 written as 0. When a set and a clear meet in one cycle, the set wins.
- R9: A `rx_break` pulse sets the break flag and `fifo_dr_set` sets data-ready. `fifo_full_set` sets receive-full and `fifo_full_clr` clears it. Any set event wins over a clear in the same cycle.
- R10: A read of 0x14 with a non-zero `fifo_count` pulses `fifo_pop` and returns `fifo_data`. With a zero count it returns 0 and does not pop. A read of 0x1C returns `fifo_count`.
- R11: FIFO control bits 7:6 select a trigger level of 1, 4, 8 or 14 on `fifo_trig`. Writing bit 1 as 1 pulses `fifo_clr` in the write cycle.
- R12: `rx_ready` equals control bit 4.
- R13: A read of 0x24 returns 0 without error. These accesses return 0 and pulse `bus_err` in the access cycle:
  - a read of 0x0C;
  - a write to 0x14 or 0x1C;
  - any misaligned offset;
  - any offset at or beyond 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write access this cycle |
| req_rd | input | 1 | Read access this cycle (exclusive with req_wr) |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid in the read cycle |
| bus_err | output | 1 | Access to an unmapped or wrong-direction offset |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_ready | output | 1 | Receiver may deliver bytes |
| rx_break | input | 1 | Break condition seen, one-cycle pulse |
| fifo_pop | output | 1 | Remove the head byte of the receive FIFO |
| fifo_clr | output | 1 | Empty the receive FIFO |
| fifo_trig | output | 5 | Receive trigger level |
| fifo_count | input | 5 | Receive FIFO fill count |
| fifo_data | input | 8 | Receive FIFO head byte |
| fifo_full_set | input | 1 | Receive-full set event |
| fifo_full_clr | input | 1 | Receive-full clear event |
| fifo_dr_set | input | 1 | Data-ready set event |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest situations to reach are the collisions between a flag's set event and a write-zero clear landing in the same cycle. The reassertion of the transmit flags on a status read also depends on the control register's prior state. The stimulus fires the FIFO and break pulses in the very cycle of a status or control write. It then walks the control enable bit both ways around status reads, so that both outcomes of the reassertion are seen. Masks, trigger decoding and address errors are swept over every data value and every offset of the address space.

// File: rtl/sport_csr_pkg.sv
package sport_csr_pkg;

  // register slot indices (offset / 4)
  localparam int NREG     = 10;
  localparam int S_MODE   = 0;
  localparam int S_BAUD   = 1;
  localparam int S_CTRL   = 2;
  localparam int S_TXD    = 3;
  localparam int S_STAT   = 4;
  localparam int S_RXD    = 5;
  localparam int S_FCTL   = 6;
  localparam int S_RCNT   = 7;
  localparam int S_PIN    = 8;
  localparam int S_LINE   = 9;

  // which slots accept reads / writes
  localparam logic [NREG-1:0] RD_OK = 10'b11_1111_0111;
  localparam logic [NREG-1:0] WR_OK = 10'b11_0101_1111;

  localparam logic [7:0] MODE_MASK = 8'h7B;
  localparam logic [7:0] CTRL_MASK = 8'hFA;
  localparam logic [7:0] PIN_MASK  = 8'hF3;

  localparam logic [7:0] BAUD_RST  = 8'hFF;
  localparam logic [7:0] CTRL_RST  = 8'h20;

  // control bits
  localparam int C_TXIE = 7;
  localparam int C_RXIE = 6;
  localparam int C_TXEN = 5;
  localparam int C_RXEN = 4;

  // status bits
  localparam int F_TEND = 6;
  localparam int F_TDE  = 5;
  localparam int F_BRK  = 4;
  localparam int F_RDF  = 1;
  localparam int F_DR   = 0;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/sport_csr_decode.sv
module sport_csr_decode
  import sport_csr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit,
  output logic            rd_bad,
  output logic            wr_bad
);
  localparam int IW = AW - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    assign hit[i] = aligned && (addr[AW-1:2] == IW'(i));
  end

  assign rd_bad = ~|(hit & RD_OK);
  assign wr_bad = ~|(hit & WR_OK);

endmodule

// File: rtl/sport_csr_regs.sv
module sport_csr_regs
  import sport_csr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          hit_mode,
  input  logic          hit_baud,
  input  logic          hit_ctrl,
  input  logic          hit_txd,
  input  logic          hit_fctl,
  input  logic          hit_pin,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] baud_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] fctl_q,
  output logic [DW-1:0] pin_q,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          fifo_clr,
  output logic [4:0]    fifo_trig
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      baud_q <= DW'(BAUD_RST);
      ctrl_q <= DW'(CTRL_RST);
      fctl_q <= '0;
      pin_q  <= '0;
    end else if (wr) begin
      if (hit_mode) mode_q <= wdata & DW'(MODE_MASK);
      if (hit_baud) baud_q <= wdata;
      if (hit_ctrl) ctrl_q <= wdata & DW'(CTRL_MASK);
      if (hit_fctl) fctl_q <= wdata;
      if (hit_pin)  pin_q  <= wdata & DW'(PIN_MASK);
    end
  end

  assign tx_valid  = wr && hit_txd;
  assign tx_data   = wdata;
  assign fifo_clr  = wr && hit_fctl && wdata[1];
  assign fifo_trig = trig_level(fctl_q[7:6]);

  // R5
  ctrl_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_ctrl) |=> (ctrl_q[C_TXIE] == $past(wdata[C_TXIE])));

  // R2
  mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_mode) |=> (mode_q == ($past(wdata) & DW'(MODE_MASK))));

endmodule

// File: rtl/sport_csr_flags.sv
module sport_csr_flags
  import sport_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic       rd_stat,
  input  logic       wr_ctrl,
  input  logic       wr_txd,
  input  logic [4:0] keep,        // {tend, tde, brk, rdf, dr} write bits
  input  logic       ctrl_rxie_new,
  input  logic       ctrl_txen_new,
  input  logic       ctrl_txen,
  input  logic       ctrl_rxie,
  input  logic       brk_in,
  input  logic       full_set,
  input  logic       full_clr,
  input  logic       dr_set,
  output logic [7:0] status,
  output logic       rx_irq
);
  logic tend, tde, brk, rdf, dr;
  logic clr_tend, clr_tde, clr_brk, clr_rdf, clr_dr, reassert;

  assign clr_tend = wr_stat && !keep[4];
  assign clr_tde  = wr_stat && !keep[3];
  assign clr_brk  = wr_stat && !keep[2];
  assign clr_rdf  = wr_stat && !keep[1];
  assign clr_dr   = wr_stat && !keep[0];
  assign reassert = rd_stat && ctrl_txen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tend   <= 1'b1;
      tde    <= 1'b1;
      brk    <= 1'b0;
      rdf    <= 1'b0;
      dr     <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      tend <= (tend && !clr_tend) || (wr_ctrl && !ctrl_txen_new) || reassert;
      tde  <= (tde && !clr_tde && !wr_txd) || reassert;
      brk  <= (brk && !clr_brk) || brk_in;
      rdf  <= (rdf && !clr_rdf && !full_clr) || full_set;
      dr   <= (dr && !clr_dr) || dr_set;
      rx_irq <= (rx_irq && !(wr_ctrl && !ctrl_rxie_new) && !clr_rdf && !clr_dr)
                || (full_set && ctrl_rxie);
    end
  end

  always_comb begin
    status         = '0;
    status[F_TEND] = tend;
    status[F_TDE]  = tde;
    status[F_BRK]  = brk;
    status[F_RDF]  = rdf;
    status[F_DR]   = dr;
  end

  // R7
  stat_read_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ctrl_txen) |=> (tde && tend));

  // R3
  txd_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> !tde);

  // R8
  rx_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(full_set && ctrl_rxie));

  // R9
  break_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |=> brk);

endmodule

// File: rtl/sport_csr_bank.sv
module sport_csr_bank
  import sport_csr_pkg::*;
#(
  parameter int AW  = 6,
  parameter int DW  = 8,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_err,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          rx_ready,
  input  logic          rx_break,
  output logic          fifo_pop,
  output logic          fifo_clr,
  output logic [4:0]    fifo_trig,
  input  logic [CW-1:0] fifo_count,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_full_set,
  input  logic          fifo_full_clr,
  input  logic          fifo_dr_set,
  output logic          tx_irq,
  output logic          rx_irq
);
  logic [NREG-1:0] hit;
  logic            rd_bad, wr_bad;
  logic [DW-1:0]   mode_q, baud_q, ctrl_q, fctl_q, pin_q;
  logic [7:0]      status;
  logic            fifo_nonempty;

  sport_csr_decode #(.AW(AW)) u_decode (
    .addr   (req_addr),
    .hit    (hit),
    .rd_bad (rd_bad),
    .wr_bad (wr_bad)
  );

  sport_csr_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (req_wr),
    .hit_mode  (hit[S_MODE]),
    .hit_baud  (hit[S_BAUD]),
    .hit_ctrl  (hit[S_CTRL]),
    .hit_txd   (hit[S_TXD]),
    .hit_fctl  (hit[S_FCTL]),
    .hit_pin   (hit[S_PIN]),
    .wdata     (req_wdata),
    .mode_q    (mode_q),
    .baud_q    (baud_q),
    .ctrl_q    (ctrl_q),
    .fctl_q    (fctl_q),
    .pin_q     (pin_q),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .fifo_clr  (fifo_clr),
    .fifo_trig (fifo_trig)
  );

  sport_csr_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stat       (req_wr && hit[S_STAT]),
    .rd_stat       (req_rd && hit[S_STAT]),
    .wr_ctrl       (req_wr && hit[S_CTRL]),
    .wr_txd        (req_wr && hit[S_TXD]),
    .keep          ({req_wdata[F_TEND], req_wdata[F_TDE], req_wdata[F_BRK],
                     req_wdata[F_RDF], req_wdata[F_DR]}),
    .ctrl_rxie_new (req_wdata[C_RXIE]),
    .ctrl_txen_new (req_wdata[C_TXEN]),
    .ctrl_txen     (ctrl_q[C_TXEN]),
    .ctrl_rxie     (ctrl_q[C_RXIE]),
    .brk_in        (rx_break),
    .full_set      (fifo_full_set),
    .full_clr      (fifo_full_clr),
    .dr_set        (fifo_dr_set),
    .status        (status),
    .rx_irq        (rx_irq)
  );

  assign tx_irq   = ctrl_q[C_TXIE];
  assign rx_ready = ctrl_q[C_RXEN];

  assign fifo_nonempty = (fifo_count != '0);
  assign fifo_pop      = req_rd && hit[S_RXD] && fifo_nonempty;
  assign bus_err       = (req_rd && rd_bad) || (req_wr && wr_bad);

  always_comb begin
    rsp_rdata = '0;
    if (req_rd) begin
      if (hit[S_MODE]) rsp_rdata = mode_q;
      if (hit[S_BAUD]) rsp_rdata = baud_q;
      if (hit[S_CTRL]) rsp_rdata = ctrl_q;
      if (hit[S_STAT]) rsp_rdata = DW'(status);
      if (hit[S_RXD] && fifo_nonempty) rsp_rdata = fifo_data;
      if (hit[S_FCTL]) rsp_rdata = fctl_q;
      if (hit[S_RCNT]) rsp_rdata = DW'(fifo_count);
      if (hit[S_PIN])  rsp_rdata = pin_q;
    end
  end

  // R13
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ((req_rd || req_wr) && (rsp_rdata == '0)));

  // R10
  pop_returns_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rsp_rdata == fifo_data));

  // R5
  tx_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_wr && hit[S_CTRL]) |-> $stable(tx_irq));

endmodule

// File: tb/sport_csr_bank_bench.sv
module sport_csr_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_wr = 0, req_rd = 0;
  logic [5:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic [7:0] rsp_rdata;
  logic       bus_err, tx_valid, rx_ready, fifo_pop, fifo_clr, tx_irq, rx_irq;
  logic [7:0] tx_data;
  logic [4:0] fifo_trig;
  logic       rx_break = 0, fifo_full_set = 0, fifo_full_clr = 0, fifo_dr_set = 0;
  logic [4:0] fifo_count = 0;
  logic [7:0] fifo_data = 0;

  int n_chk = 0;
  int n_err = 0;

  // sampled during the last access
  logic [7:0] s_rdata;
  logic       s_err, s_txv, s_pop, s_clr;
  logic [7:0] s_txd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_csr_bank u_sport_csr_bank (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .bus_err(bus_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_ready(rx_ready), .rx_break(rx_break), .fifo_pop(fifo_pop),
    .fifo_clr(fifo_clr), .fifo_trig(fifo_trig), .fifo_count(fifo_count),
    .fifo_data(fifo_data), .fifo_full_set(fifo_full_set),
    .fifo_full_clr(fifo_full_clr), .fifo_dr_set(fifo_dr_set),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr_op(input logic [5:0] a, input logic [7:0] d);
    req_wr = 1; req_rd = 0; req_addr = a; req_wdata = d;
    #1;
    s_err = bus_err; s_txv = tx_valid; s_txd = tx_data; s_clr = fifo_clr;
    @(negedge clk);
    req_wr = 0;
  endtask

  task automatic rd_op(input logic [5:0] a);
    req_rd = 1; req_wr = 0; req_addr = a;
    #1;
    s_rdata = rsp_rdata; s_err = bus_err; s_pop = fifo_pop;
    @(negedge clk);
    req_rd = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic int trig_of(input int v);
    case ((v >> 6) & 3)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit rd_legal(input int a);
    int i;
    i = a / 4;
    return (a % 4 == 0) && (i <= 9) && (i != 3);
  endfunction

  function automatic bit wr_legal(input int a);
    int i;
    i = a / 4;
    return (a % 4 == 0) && (i <= 9) && (i != 5) && (i != 7);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle();

    // R1 reset state
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 trig", fifo_trig, 1);
    chk("R12 rx_ready reset", rx_ready, 0);
    rd_op(6'h10); chk("R1 status", s_rdata, 8'h60);
    rd_op(6'h04); chk("R1 baud", s_rdata, 8'hFF);
    rd_op(6'h08); chk("R1 ctrl", s_rdata, 8'h20);
    rd_op(6'h00); chk("R1 mode", s_rdata, 0);
    rd_op(6'h18); chk("R1 fctl", s_rdata, 0);
    rd_op(6'h20); chk("R1 pin", s_rdata, 0);

    // R2 R5 R11 R12 sweep of all data values
    for (int v = 0; v < 256; v++) begin
      wr_op(6'h00, 8'(v)); rd_op(6'h00); chk("R2 mode mask", s_rdata, v & 8'h7B);
      wr_op(6'h04, 8'(v)); rd_op(6'h04); chk("R2 baud", s_rdata, v);
      wr_op(6'h20, 8'(v)); rd_op(6'h20); chk("R2 pin mask", s_rdata, v & 8'hF3);
      wr_op(6'h18, 8'(v));
      chk("R11 fifo_clr", s_clr, (v >> 1) & 1);
      chk("R11 trig", fifo_trig, trig_of(v));
      rd_op(6'h18); chk("R2 fctl", s_rdata, v);
      wr_op(6'h08, 8'(v));
      chk("R5 tx_irq", tx_irq, (v >> 7) & 1);
      chk("R12 rx_ready", rx_ready, (v >> 4) & 1);
      rd_op(6'h08); chk("R2 ctrl mask", s_rdata, v & 8'hFA);
    end
    wr_op(6'h08, 8'h20);

    // R3 transmit strobe and empty flag
    rd_op(6'h10);
    wr_op(6'h0C, 8'hA5);
    chk("R3 tx_valid", s_txv, 1);
    chk("R3 tx_data", s_txd, 8'hA5);
    chk("R3 no error", s_err, 0);
    idle(); chk("R3 strobe one cycle", tx_valid, 0);
    rd_op(6'h10); chk("R3 empty cleared", s_rdata, 8'h40);
    // R7 reassert with transmit enabled
    rd_op(6'h10); chk("R7 reassert", s_rdata, 8'h60);

    // R7 no reassert when disabled; R4 ctrl write sets transmit-end
    wr_op(6'h08, 8'h00);
    wr_op(6'h10, 8'h00);
    rd_op(6'h10); chk("R6 all cleared", s_rdata, 0);
    rd_op(6'h10); chk("R7 no reassert", s_rdata, 0);
    wr_op(6'h08, 8'h00);
    rd_op(6'h10); chk("R4 tend set", s_rdata, 8'h40);
    wr_op(6'h10, 8'h00);
    wr_op(6'h08, 8'h20);
    rd_op(6'h10); chk("R4 bit5 set no tend", s_rdata, 0);
    rd_op(6'h10); chk("R7 reassert after enable", s_rdata, 8'h60);

    // R6 R9 flag set / clear
    wr_op(6'h08, 8'h00);
    wr_op(6'h10, 8'h00);
    rx_break = 1; idle(); rx_break = 0;
    fifo_full_set = 1; idle(); fifo_full_set = 0;
    fifo_dr_set = 1; idle(); fifo_dr_set = 0;
    rd_op(6'h10); chk("R9 sets", s_rdata, 8'h13);
    wr_op(6'h10, 8'hFF); rd_op(6'h10); chk("R6 write one keeps", s_rdata, 8'h13);
    wr_op(6'h10, 8'hEF); rd_op(6'h10); chk("R6 clear brk", s_rdata, 8'h03);
    wr_op(6'h10, 8'hFD); rd_op(6'h10); chk("R6 clear rdf", s_rdata, 8'h01);
    wr_op(6'h10, 8'hFE); rd_op(6'h10); chk("R6 clear dr", s_rdata, 8'h00);
    fifo_full_set = 1; idle(); fifo_full_set = 0;
    fifo_full_clr = 1; idle(); fifo_full_clr = 0;
    rd_op(6'h10); chk("R9 full clr", s_rdata, 0);
    fifo_full_set = 1; fifo_full_clr = 1; idle();
    fifo_full_set = 0; fifo_full_clr = 0;
    rd_op(6'h10); chk("R9 set wins", s_rdata, 8'h02);
    rx_break = 1; wr_op(6'h10, 8'h00); rx_break = 0;
    rd_op(6'h10); chk("R9 break wins over write", s_rdata, 8'h10);

    // R8 receive interrupt
    wr_op(6'h10, 8'h00);
    wr_op(6'h08, 8'h40);
    fifo_full_set = 1; idle(); fifo_full_set = 0;
    chk("R8 irq set", rx_irq, 1);
    wr_op(6'h10, 8'hFF); chk("R8 ones keep irq", rx_irq, 1);
    wr_op(6'h10, 8'hFD); chk("R8 clr by rdf bit", rx_irq, 0);
    fifo_full_set = 1; idle(); fifo_full_set = 0;
    wr_op(6'h10, 8'hFE); chk("R8 clr by dr bit", rx_irq, 0);
    fifo_full_set = 1; idle(); fifo_full_set = 0;
    chk("R8 irq set again", rx_irq, 1);
    wr_op(6'h08, 8'h00); chk("R8 clr by ctrl", rx_irq, 0);
    fifo_full_set = 1; idle(); fifo_full_set = 0;
    chk("R8 disabled", rx_irq, 0);
    wr_op(6'h08, 8'h40);
    fifo_full_set = 1; wr_op(6'h10, 8'h00); fifo_full_set = 0;
    chk("R8 set wins", rx_irq, 1);

    // R10 receive data and count
    fifo_count = 0; fifo_data = 8'h5C;
    rd_op(6'h14);
    chk("R10 empty data", s_rdata, 0);
    chk("R10 empty no pop", s_pop, 0);
    fifo_count = 3;
    rd_op(6'h14);
    chk("R10 data", s_rdata, 8'h5C);
    chk("R10 pop", s_pop, 1);
    for (int c = 0; c <= 16; c++) begin
      fifo_count = 5'(c);
      rd_op(6'h1C); chk("R10 count", s_rdata, c);
    end
    fifo_count = 0;

    // R13 line status and address sweep
    rd_op(6'h24); chk("R13 line status", s_rdata, 0); chk("R13 line ok", s_err, 0);
    for (int a = 0; a < 64; a++) begin
      rd_op(6'(a));
      chk("R13 read err", s_err, rd_legal(a) ? 0 : 1);
      if (!rd_legal(a)) chk("R13 read zero", s_rdata, 0);
      if (!wr_legal(a)) begin
        wr_op(6'(a), 8'hFF);
        chk("R13 write err", s_err, 1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule